// File: doc/BRIEF.md
# Frame Relay Pseudowire Encapsulator

This block sits on the customer-facing side of a provider edge and turns frame relay frames into pseudowire packets. Each frame arrives as a byte stream of its information field. The header bits recovered by an upstream deframer (command/response, discard eligibility, forward and backward congestion notices), the payload byte count and a per-frame policing mark travel as sideband signals that stay steady while the frame is offered. The block emits a byte stream made of an MPLS label stack, a 32-bit control word and then the payload bytes, unchanged.

Static configuration selects the pseudowire label, the outer transport labels, the EXP class, the TTL, whether sequencing is used, and whether a policing mark may promote a frame to discard eligible. The discard flag only ever moves one way: a frame marked discard eligible by the customer always leaves marked. Both edges use a valid/ready handshake. The input is held off while the header bytes are sent, and the output may stall at any beat without losing or corrupting data.

Top module: `fr_pw_encap`

## Requirements
- R1: When a frame arrives with `in_de`=1, control word bit 25 (D) is 1, whatever the policing inputs are.
- R2: With `in_de`=0, D is 1 exactly when `in_police`=1 and `cfg_police_en`=1; otherwise D is 0.
- R3: Control word bit 27 (F) equals `in_fecn`, bit 26 (B) equals `in_becn`, bit 24 (C) equals `in_cr`; bits 31:28 and 23:22 are 0.
- R4: When `cfg_seq_en`=0 at a frame's start, control word bits 15:0 are 0 and the sequence counter keeps its value for the next sequenced frame.
- R5: When `cfg_seq_en`=1, bits 15:0 carry the counter, which is 1 for the first sequenced frame after reset, rises by 1 per sequenced frame, and wraps from its all-ones value (2^SEQ_W-1) to 1, never producing 0.
- R6: Control word bits 21:16 hold the payload length when payload length + 4 is less than MIN_PKT (64), and 0 otherwise.
- R7: The label stack is NUM_OUTER outer labels (index 0 of `cfg_outer_labels` first) then the pseudowire label, each sent as four bytes, most significant first, of {label[19:0], EXP[2:0], S, TTL[7:0]}; S is 1 on the pseudowire label only.
- R8: Every label in the stack carries `cfg_exp` in its EXP field and `cfg_ttl` as its TTL.
- R9: Output order per packet is label stack, control word (most significant byte first), then the payload bytes unchanged; `out_last` is 1 only with the final payload byte, and nothing is emitted while no frame is offered.
- R10: While `out_valid`=1 and `out_ready`=0 the output byte and `out_last` hold steady into the next cycle; `in_ready` is 0 until the whole header has been accepted, and no byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_seq_en | input | 1 | Sequencing enabled for this pseudowire |
| cfg_police_en | input | 1 | Allow policing mark to set D |
| cfg_exp | input | 3 | EXP class for every label |
| cfg_ttl | input | 8 | TTL for every label |
| cfg_pw_label | input | 20 | Pseudowire (bottom) label value |
| cfg_outer_labels | input | NUM_OUTER*20 | Outer labels, index 0 sent first |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte accepted |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Final payload byte of the frame |
| in_len | input | 16 | Payload byte count of the frame |
| in_cr | input | 1 | Frame command/response bit |
| in_de | input | 1 | Frame discard eligibility bit |
| in_fecn | input | 1 | Frame forward congestion bit |
| in_becn | input | 1 | Frame backward congestion bit |
| in_police | input | 1 | Ingress policer marked this frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the packet |

## Verification
On every cycle the assertions guard the one-way discard flag, the bottom-of-stack and EXP fields as they are latched, the length field clearing for long frames, the sequence counter never reaching zero and stepping or holding correctly, and header bytes staying put under a stall. Only the bench scenarios can show the byte-exact packet layout across varying label and payload contents, the counter wrap reached over many frames, interleaving of sequenced and unsequenced frames, and completeness of the payload under random backpressure.

// File: rtl/fr_pw_pkg.sv
package fr_pw_pkg;

  localparam int LBL_W  = 20;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic cr;
    logic de;
    logic fecn;
    logic becn;
    logic police;
  } fr_flags_t;

  typedef enum logic [1:0] {
    EM_IDLE = 2'd0,
    EM_HDR  = 2'd1,
    EM_PAY  = 2'd2
  } emit_state_t;

  // One MPLS stack entry: label, class, bottom flag, hop limit.
  function automatic logic [WORD_W-1:0] mk_label(
    input logic [LBL_W-1:0] lbl,
    input logic [2:0]       exp_cls,
    input logic             bos,
    input logic [7:0]       ttl
  );
    return {lbl, exp_cls, bos, ttl};
  endfunction

  // Length field: payload count for short packets, else zero.
  function automatic logic [5:0] len_field(
    input logic [15:0] plen,
    input int          min_pkt
  );
    if ((int'(plen) + 4) < min_pkt) return plen[5:0];
    return 6'd0;
  endfunction

  // Discard flag may be raised by policing but never dropped.
  function automatic logic d_flag(
    input fr_flags_t f,
    input logic      pol_en
  );
    return f.de | (f.police & pol_en);
  endfunction

  function automatic logic [WORD_W-1:0] mk_cw(
    input fr_flags_t   f,
    input logic        pol_en,
    input logic [5:0]  len,
    input logic [15:0] seq
  );
    return {4'b0000, f.fecn, f.becn, d_flag(f, pol_en), f.cr, 2'b00, len, seq};
  endfunction

endpackage

// File: rtl/fr_pw_seq.sv
module fr_pw_seq #(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [SEQ_W-1:0] seq_q
);

  localparam logic [SEQ_W-1:0] SEQ_TOP = {SEQ_W{1'b1}};
  localparam logic [SEQ_W-1:0] SEQ_ONE = SEQ_W'(1);

  logic [SEQ_W-1:0] seq_d;

  always_comb begin
    seq_d = seq_q;
    if (adv) seq_d = (seq_q == SEQ_TOP) ? SEQ_ONE : seq_q + SEQ_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) seq_q <= SEQ_ONE;
    else        seq_q <= seq_d;
  end

  // R5
  seq_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_q != '0);

  // R5
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ((seq_q == $past(seq_q) + SEQ_ONE) ||
             (($past(seq_q) == SEQ_TOP) && (seq_q == SEQ_ONE))));

  // R4
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(seq_q));

endmodule

// File: rtl/fr_pw_hdr_build.sv
module fr_pw_hdr_build
  import fr_pw_pkg::*;
#(
  parameter int NUM_OUTER = 1,
  parameter int SEQ_W     = 16,
  parameter int MIN_PKT   = 64,
  parameter int HDR_BITS  = (NUM_OUTER + 2) * 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  fr_flags_t                 flags,
  input  logic [15:0]               plen,
  input  logic                      cfg_police_en,
  input  logic                      cfg_seq_en,
  input  logic [2:0]                cfg_exp,
  input  logic [7:0]                cfg_ttl,
  input  logic [LBL_W-1:0]          cfg_pw_label,
  input  logic [NUM_OUTER*LBL_W-1:0] cfg_outer_labels,
  input  logic [SEQ_W-1:0]          seq_val,
  output logic [HDR_BITS-1:0]       hdr_q
);

  localparam int HDR_WORDS = NUM_OUTER + 2;
  localparam int PW_LSB    = (HDR_WORDS - 1 - NUM_OUTER) * WORD_W;

  logic [HDR_BITS-1:0] hdr_d;
  logic [15:0]         seq16;

  always_comb begin
    seq16 = '0;
    if (cfg_seq_en) seq16[SEQ_W-1:0] = seq_val;
  end

  for (genvar k = 0; k < NUM_OUTER; k++) begin : g_outer
    localparam int LSB = (HDR_WORDS - 1 - k) * WORD_W;
    assign hdr_d[LSB +: WORD_W] =
      mk_label(cfg_outer_labels[k*LBL_W +: LBL_W], cfg_exp, 1'b0, cfg_ttl);

    // R7
    outer_bos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !hdr_q[LSB + 8]);
  end

  assign hdr_d[PW_LSB +: WORD_W] = mk_label(cfg_pw_label, cfg_exp, 1'b1, cfg_ttl);
  assign hdr_d[WORD_W-1:0]       = mk_cw(flags, cfg_police_en,
                                         len_field(plen, MIN_PKT), seq16);

  always_ff @(posedge clk) begin
    if (!rst_n)    hdr_q <= '0;
    else if (load) hdr_q <= hdr_d;
  end

  for (genvar k = 0; k <= NUM_OUTER; k++) begin : g_exp
    localparam int LSB = (HDR_WORDS - 1 - k) * WORD_W;
    // R8
    stack_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (hdr_q[LSB + 9 +: 3] == $past(cfg_exp)));
  end

  // R7
  pw_bos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> hdr_q[PW_LSB + 8]);

  // R1
  discard_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && flags.de) |=> hdr_q[25]);

  // R6
  long_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ((int'(plen) + 4) >= MIN_PKT)) |=> (hdr_q[21:16] == 6'd0));

endmodule

// File: rtl/fr_pw_emit.sv
module fr_pw_emit
  import fr_pw_pkg::*;
#(
  parameter int HDR_BYTES = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [HDR_BYTES*8-1:0] hdr_q,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [7:0]             in_data,
  input  logic                   in_last,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [7:0]             out_data,
  output logic                   out_last,
  output logic                   start
);

  localparam int IDX_W = (HDR_BYTES > 1) ? $clog2(HDR_BYTES) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_BYTES - 1);

  emit_state_t      state_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       hdr_byte;
  logic             hdr_beat;
  logic             hdr_done;
  logic             pay_end;

  assign hdr_byte = hdr_q[(HDR_BYTES - 1 - int'(idx_q)) * 8 +: 8];

  assign start    = (state_q == EM_IDLE) && in_valid;
  assign hdr_beat = (state_q == EM_HDR) && out_ready;
  assign hdr_done = hdr_beat && (idx_q == IDX_LAST);
  assign pay_end  = (state_q == EM_PAY) && in_valid && out_ready && in_last;

  always_comb begin
    out_valid = 1'b0;
    out_data  = 8'd0;
    out_last  = 1'b0;
    in_ready  = 1'b0;
    case (state_q)
      EM_HDR: begin
        out_valid = 1'b1;
        out_data  = hdr_byte;
      end
      EM_PAY: begin
        out_valid = in_valid;
        out_data  = in_data;
        out_last  = in_last;
        in_ready  = out_ready;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= EM_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        EM_IDLE: if (start) begin
          state_q <= EM_HDR;
          idx_q   <= '0;
        end
        EM_HDR: if (hdr_done) begin
          state_q <= EM_PAY;
          idx_q   <= '0;
        end else if (hdr_beat) begin
          idx_q <= idx_q + 1'b1;
        end
        EM_PAY: if (pay_end) state_q <= EM_IDLE;
        default: state_q <= EM_IDLE;
      endcase
    end
  end

  // R10
  hdr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == EM_HDR) && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10
  hdr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !in_ready);

  // R9
  pkt_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pay_end |=> !out_valid);

  // R9
  hdr_to_pay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done |=> (state_q == EM_PAY));

endmodule

// File: rtl/fr_pw_encap.sv
module fr_pw_encap
  import fr_pw_pkg::*;
#(
  parameter int NUM_OUTER = 1,
  parameter int SEQ_W     = 16,
  parameter int MIN_PKT   = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_seq_en,
  input  logic                       cfg_police_en,
  input  logic [2:0]                 cfg_exp,
  input  logic [7:0]                 cfg_ttl,
  input  logic [19:0]                cfg_pw_label,
  input  logic [NUM_OUTER*20-1:0]    cfg_outer_labels,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [7:0]                 in_data,
  input  logic                       in_last,
  input  logic [15:0]                in_len,
  input  logic                       in_cr,
  input  logic                       in_de,
  input  logic                       in_fecn,
  input  logic                       in_becn,
  input  logic                       in_police,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [7:0]                 out_data,
  output logic                       out_last
);

  localparam int HDR_WORDS = NUM_OUTER + 2;
  localparam int HDR_BYTES = HDR_WORDS * 4;
  localparam int HDR_BITS  = HDR_WORDS * 32;

  fr_flags_t          flags;
  logic               start;
  logic               seq_adv;
  logic [SEQ_W-1:0]   seq_val;
  logic [HDR_BITS-1:0] hdr_q;

  assign flags   = '{cr: in_cr, de: in_de, fecn: in_fecn, becn: in_becn,
                     police: in_police};
  assign seq_adv = start && cfg_seq_en;

  fr_pw_seq #(.SEQ_W(SEQ_W)) i_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (seq_adv),
    .seq_q (seq_val)
  );

  fr_pw_hdr_build #(
    .NUM_OUTER (NUM_OUTER),
    .SEQ_W     (SEQ_W),
    .MIN_PKT   (MIN_PKT),
    .HDR_BITS  (HDR_BITS)
  ) i_hdr (
    .clk              (clk),
    .rst_n            (rst_n),
    .load             (start),
    .flags            (flags),
    .plen             (in_len),
    .cfg_police_en    (cfg_police_en),
    .cfg_seq_en       (cfg_seq_en),
    .cfg_exp          (cfg_exp),
    .cfg_ttl          (cfg_ttl),
    .cfg_pw_label     (cfg_pw_label),
    .cfg_outer_labels (cfg_outer_labels),
    .seq_val          (seq_val),
    .hdr_q            (hdr_q)
  );

  fr_pw_emit #(.HDR_BYTES(HDR_BYTES)) i_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_q     (hdr_q),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .start     (start)
  );

endmodule

// File: tb/test_fr_pw_encap.sv
module test_fr_pw_encap;

  localparam int NO   = 2;
  localparam int SW   = 6;
  localparam int MINP = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_seq_en = 1'b0, cfg_police_en = 1'b0;
  logic [2:0] cfg_exp = '0;
  logic [7:0] cfg_ttl = '0;
  logic [19:0] cfg_pw_label = '0;
  logic [NO*20-1:0] cfg_outer_labels = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic [15:0] in_len = '0;
  logic in_cr = 0, in_de = 0, in_fecn = 0, in_becn = 0, in_police = 0;
  logic in_ready, out_valid, out_last;
  logic out_ready = 1'b0;
  logic [7:0] out_data;

  fr_pw_encap #(.NUM_OUTER(NO), .SEQ_W(SW), .MIN_PKT(MINP)) i_fr_pw_encap (
    .clk(clk), .rst_n(rst_n), .cfg_seq_en(cfg_seq_en), .cfg_police_en(cfg_police_en),
    .cfg_exp(cfg_exp), .cfg_ttl(cfg_ttl), .cfg_pw_label(cfg_pw_label),
    .cfg_outer_labels(cfg_outer_labels), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_len(in_len), .in_cr(in_cr),
    .in_de(in_de), .in_fecn(in_fecn), .in_becn(in_becn), .in_police(in_police),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last));

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int bp_pct = 0;
  int exp_seq = 1;
  logic [7:0] q_byte[$];
  logic       q_last[$];
  string      q_tag[$];

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic l, input string tag);
    q_byte.push_back(b);
    q_last.push_back(l);
    q_tag.push_back(tag);
  endtask

  // Bench view of the length rule.
  function automatic int want_len(input int n);
    return (n <= MINP - 5) ? n : 0;
  endfunction

  function automatic int next_seq(input int s);
    return (s == (1 << SW) - 1) ? 1 : s + 1;
  endfunction

  task automatic push_label(input logic [19:0] v, input logic bos);
    push(v[19:12], 1'b0, "R7 label hi");
    push(v[11:4],  1'b0, "R7 label mid");
    push({v[3:0], cfg_exp, bos}, 1'b0, "R8 R7 exp/S");
    push(cfg_ttl, 1'b0, "R8 ttl");
  endtask

  logic [7:0] pay [0:127];

  task automatic send_frame(input int n, input logic cr, de, fe, be, pol);
    int sq;
    logic dbit;
    in_len = 16'(n); in_cr = cr; in_de = de; in_fecn = fe; in_becn = be; in_police = pol;
    for (int k = 0; k < NO; k++) push_label(cfg_outer_labels[k*20 +: 20], 1'b0);
    push_label(cfg_pw_label, 1'b1);
    if (de) dbit = 1'b1;
    else    dbit = pol && cfg_police_en;
    sq = 0;
    if (cfg_seq_en) begin
      sq = exp_seq;
      exp_seq = next_seq(exp_seq);
    end
    push({4'h0, fe, be, dbit, cr}, 1'b0, de ? "R1 R3 cw flags" : "R2 R3 cw flags");
    push(8'(want_len(n)), 1'b0, "R6 cw length");
    push(8'(sq >> 8), 1'b0, cfg_seq_en ? "R5 seq hi" : "R4 seq hi");
    push(8'(sq), 1'b0, cfg_seq_en ? "R5 seq lo" : "R4 seq lo");
    for (int i = 0; i < n; i++) begin
      pay[i] = 8'($urandom);
      push(pay[i], i == n - 1, "R9 payload");
    end
    for (int i = 0; i < n; i++) begin
      bit acc;
      in_data = pay[i];
      in_last = (i == n - 1);
      in_valid = 1'b1;
      acc = 1'b0;
      while (!acc) begin
        #4;
        acc = in_ready;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    in_last = 1'b0;
  endtask

  // Output side: drive ready, sample just before the rising edge.
  logic       prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  logic       prev_last = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      out_ready = ($urandom % 100) >= bp_pct;
      #4;
      if (rst_n && prev_stall)
        check(out_valid && out_data == prev_data && out_last == prev_last,
              "R10 stall hold", {out_valid, out_last, out_data}, {1'b1, prev_last, prev_data});
      if (rst_n && out_valid && out_ready) begin
        if (q_byte.size() == 0) begin
          check(1'b0, "R10 extra byte", out_data, 0);
        end else begin
          logic [7:0] eb;
          logic el;
          string t;
          eb = q_byte.pop_front(); el = q_last.pop_front(); t = q_tag.pop_front();
          check(out_data == eb && out_last == el, t, {out_last, out_data}, {el, eb});
        end
      end
      prev_stall = rst_n && out_valid && !out_ready;
      prev_data  = out_data;
      prev_last  = out_last;
    end
  end

  task automatic set_cfg(input logic se, pe);
    cfg_seq_en = se; cfg_police_en = pe;
    cfg_exp = 3'($urandom); cfg_ttl = 8'($urandom);
    cfg_pw_label = 20'($urandom);
    cfg_outer_labels = {20'($urandom), 20'($urandom)};
  endtask

  task automatic drain();
    int t = 0;
    while (q_byte.size() != 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
  endtask

  initial begin
    void'($urandom(32'd20250708));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #4;
    check(!out_valid, "R9 reset out_valid", out_valid, 0);
    check(!in_ready, "R10 reset in_ready", in_ready, 0);
    @(negedge clk);

    // Directed corners
    set_cfg(1, 1); send_frame(1, 1, 1, 0, 0, 1);   // DE set, policed
    set_cfg(1, 0); send_frame(59, 0, 1, 1, 1, 0);  // DE set, longest short frame
    set_cfg(0, 0); send_frame(60, 1, 0, 0, 1, 1);  // police ignored, first long frame
    set_cfg(1, 1); send_frame(3, 0, 0, 1, 0, 1);   // police promotes D
    set_cfg(0, 1); send_frame(100, 0, 0, 0, 0, 0); // nothing set, seq off
    bp_pct = 80;
    set_cfg(1, 0); send_frame(17, 1, 1, 1, 1, 1);
    drain();

    // Random frames with varying backpressure
    for (int f = 0; f < 200; f++) begin
      bp_pct = (f % 3 == 0) ? 60 : ((f % 3 == 1) ? 0 : 25);
      set_cfg(($urandom % 4) != 0, $urandom % 2);
      send_frame(1 + ($urandom % 90), $urandom % 2, $urandom % 2, $urandom % 2,
                 $urandom % 2, $urandom % 2);
    end
    drain();
    repeat (5) @(negedge clk);
    check(q_byte.size() == 0, "R10 all bytes delivered", q_byte.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule